// File: doc/BRIEF.md
# Delta-Sigma Bitstream Output Port

This block sits between a 1-bit delta-sigma modulator and the output pins of a converter. It divides the system clock by two to make the modulator tick. It takes in one modulator bit per tick and drives a data pin and a clock pin, each with an inverted partner pin. A 2-bit mode input picks one of four output formats:

- a full-rate synchronous clock with data;
- a half-rate clock with data sampled on both of its edges;
- a clockless Manchester stream on the data pair only;
- a synchronous format for use when the system clock itself comes from outside the chip.

Every output is registered on the system clock. One modulator bit period is two system-clock cycles: a first half and a second half. The modulator presents its bit and a valid flag in the cycle where `mod_tick` is high. The bit is captured at the end of that cycle and is shown during the next bit period. A new mode value is accepted only at the end of a bit period, so a bit is never emitted partly in one format and partly in another.

Top module: `bitstream_port`

## Requirements
- R1: `mod_tick` is low in the first half and high in the second half of every bit period, so it alternates every system cycle. When `mod_tick` and `mod_bit_vld` are both high, `mod_bit` is captured at that clock edge and appears on the outputs during the whole following bit period.
- R2: With `mode_sel` = 2'b00, `cko` is low in the first half and high in the second half of the period. `dout` holds the bit for the whole period. Data therefore changes on the falling edge of `cko` and is stable at its rising edge.
- R3: With `mode_sel` = 2'b01, `cko` has a period of two bit periods. In the first bit period after the mode is taken, `cko` is low in the first half and high in the second half. In the next bit period it is high in the first half and low in the second half, and this two-period pattern then repeats. `dout` holds each bit for one bit period, so every `cko` edge falls in the middle of a data bit.
- R4: With `mode_sel` = 2'b10, `dout` carries the bit in the first half and its inverse in the second half, so a 1 is sent as high then low. `cko` and `cko_n` are both held low.
- R5: With `mode_sel` = 2'b11, the data and clock timing is the same as in R2: the output clock runs at half the system clock and data updates on every second system clock.
- R6: Outside reset, `dout_n` is always the inverse of `dout`. `cko_n` is always the inverse of `cko`, except in the Manchester mode of R4.
- R7: A change of `mode_sel` takes effect only at the clock edge that ends a bit period, and a value that is present only during a first half has no effect. When the accepted mode differs from the active one, the divider restarts, so the first period in the new mode begins with `cko` low and `mod_tick` low.
- R8: A synchronous active-high `rst` drives `dout`, `dout_n`, `cko` and `cko_n` low. It clears the divider phase, so `mod_tick` is low, selects mode 2'b00, and clears the held bit to 0.
- R9: If `mod_bit_vld` is low when `mod_tick` is high, the previously captured bit is sent again in the next bit period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Output format request, taken at bit-period ends |
| mod_bit | input | 1 | Modulator output bit |
| mod_bit_vld | input | 1 | `mod_bit` is valid in this tick cycle |
| mod_tick | output | 1 | Modulator clock enable, high in the last cycle of each bit period |
| dout | output | 1 | Serial data |
| dout_n | output | 1 | Inverted serial data |
| cko | output | 1 | Output clock |
| cko_n | output | 1 | Inverted output clock, held low in Manchester mode |

## Verification
The assertions assume that `rst` is held for at least one clock edge before the outputs are judged. They do not assume that `mode_sel` or `mod_bit` are steady: in-period glitches on `mode_sel` are legal input and must not reach the outputs. The stimulus changes the inputs only at the falling clock edge. It presents each new bit and mode in the tick cycle, the way a modulator driven by `mod_tick` would. It deliberately flips `mode_sel` in a first half and restores it before the period ends, to show that such a glitch is ignored. The bench sweeps every 8-bit pattern through each mode, plus gaps in `mod_bit_vld` and a reset in mid-stream. It computes the expected pin levels from the mode, the half of the period and, for the half-rate clock, the count of periods since the mode was taken.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

    localparam int PH_W = 2;

    typedef enum logic [1:0] {
        FMT_SYNC  = 2'b00,
        FMT_HALF  = 2'b01,
        FMT_MANCH = 2'b10,
        FMT_EXT   = 2'b11
    } fmt_e;

    typedef struct packed {
        logic dat;
        logic dat_n;
        logic clk;
        logic clk_n;
    } pins_t;

    // Pin levels for one system cycle, given the format, the divider phase
    // (bit 0 = second half of a bit period) and the bit being sent.
    function automatic pins_t shape_pins(fmt_e f, logic [PH_W-1:0] ph, logic b);
        pins_t p;
        logic  d;
        logic  c;
        case (f)
            FMT_HALF:  begin d = b;         c = ph[0] ^ ph[1]; end
            FMT_MANCH: begin d = b ^ ph[0]; c = 1'b0;          end
            default:   begin d = b;         c = ph[0];         end
        endcase
        p.dat   = d;
        p.dat_n = ~d;
        p.clk   = c;
        p.clk_n = (f == FMT_MANCH) ? 1'b0 : ~c;
        return p;
    endfunction

endpackage

// File: rtl/bsp_phase.sv
module bsp_phase
    import bsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      mode_req,
    output logic            tick,
    output logic [PH_W-1:0] ph_nx,
    output fmt_e            fmt_q,
    output fmt_e            fmt_nx
);
    logic [PH_W-1:0] ph_q;

    assign tick = ph_q[0];

    always_comb begin
        fmt_nx = fmt_q;
        ph_nx  = ph_q + 1'b1;
        if (tick) begin
            fmt_nx = fmt_e'(mode_req);
            if (fmt_nx != fmt_q) begin
                ph_nx = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            fmt_q <= FMT_SYNC;
        end else begin
            ph_q  <= ph_nx;
            fmt_q <= fmt_nx;
        end
    end
endmodule

// File: rtl/bsp_capture.sv
module bsp_capture (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic bit_in,
    input  logic bit_vld,
    output logic bit_nx
);
    logic bit_q;

    assign bit_nx = (tick && bit_vld) ? bit_in : bit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            bit_q <= bit_nx;
        end
    end
endmodule

// File: rtl/bsp_shaper.sv
module bsp_shaper
    import bsp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  fmt_e            fmt_nx,
    input  logic [PH_W-1:0] ph_nx,
    input  logic            bit_nx,
    output pins_t           pins_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= '0;
        end else begin
            pins_q <= shape_pins(fmt_nx, ph_nx, bit_nx);
        end
    end
endmodule

// File: rtl/bitstream_port.sv
module bitstream_port
    import bsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       mod_bit,
    input  logic       mod_bit_vld,
    output logic       mod_tick,
    output logic       dout,
    output logic       dout_n,
    output logic       cko,
    output logic       cko_n
);
    logic [PH_W-1:0] ph_nx;
    fmt_e            act_mode;
    fmt_e            mode_nx;
    logic            bit_nx;
    pins_t           pins;

    bsp_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .mode_req (mode_sel),
        .tick     (mod_tick),
        .ph_nx    (ph_nx),
        .fmt_q    (act_mode),
        .fmt_nx   (mode_nx)
    );

    bsp_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .tick    (mod_tick),
        .bit_in  (mod_bit),
        .bit_vld (mod_bit_vld),
        .bit_nx  (bit_nx)
    );

    bsp_shaper u_shaper (
        .clk    (clk),
        .rst    (rst),
        .fmt_nx (mode_nx),
        .ph_nx  (ph_nx),
        .bit_nx (bit_nx),
        .pins_q (pins)
    );

    assign dout   = pins.dat;
    assign dout_n = pins.dat_n;
    assign cko    = pins.clk;
    assign cko_n  = pins.clk_n;
endmodule

// File: rtl/bitstream_port_chk.sv
module bitstream_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       mod_tick,
    input logic       dout,
    input logic       dout_n,
    input logic       cko,
    input logic       cko_n,
    input logic [1:0] amode
);
    logic live;

    always_ff @(posedge clk) begin
        live <= !rst;
    end

    p_tick_alt_r1: assert property (@(posedge clk) disable iff (rst)
        live |-> (mod_tick != $past(mod_tick)));

    // R2, R3 and R5: outside Manchester, data moves only at period starts
    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (live && amode != 2'b10 && !mod_tick) |=> $stable(dout));

    p_manch_clk_low_r4: assert property (@(posedge clk) disable iff (rst)
        (live && amode == 2'b10) |-> (!cko && !cko_n));

    p_manch_split_r4: assert property (@(posedge clk) disable iff (rst)
        (live && amode == 2'b10 && mod_tick) |-> (dout != $past(dout)));

    p_pair_inverse_r6: assert property (@(posedge clk) disable iff (rst)
        live |-> ((dout_n == !dout) && (amode == 2'b10 || cko_n == !cko)));

    p_mode_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(mod_tick)) |-> $stable(amode));

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (live && $past(mod_tick) && amode != $past(amode)) |-> (!mod_tick && !cko));

    p_reset_low_r8: assert property (@(posedge clk)
        rst |=> (!dout && !dout_n && !cko && !cko_n && !mod_tick));
endmodule

bind bitstream_port bitstream_port_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mod_tick (mod_tick),
    .dout     (dout),
    .dout_n   (dout_n),
    .cko      (cko),
    .cko_n    (cko_n),
    .amode    (act_mode)
);

// File: tb/bitstream_port_tb.sv
module bitstream_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       mod_bit = 1'b0;
    logic       mod_bit_vld = 1'b0;
    logic       mod_tick, dout, dout_n, cko, cko_n;

    int         errs = 0;
    int         checks = 0;
    bit         done = 1'b0;
    logic       bench_b = 1'b0;
    logic [1:0] bmode = 2'b00;
    int         per_idx = 0;

    always #4 clk = ~clk;

    bitstream_port u_dut (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .mod_bit     (mod_bit),
        .mod_bit_vld (mod_bit_vld),
        .mod_tick    (mod_tick),
        .dout        (dout),
        .dout_n      (dout_n),
        .cko         (cko),
        .cko_n       (cko_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_half(input logic [1:0] m, input int h, input string dtag, input string ctag);
        logic ed, ec;
        ed = (m == 2'b10) ? (bench_b ^ logic'(h)) : bench_b;
        case (m)
            2'b01:   ec = logic'(h) ^ logic'(per_idx & 1);
            2'b10:   ec = 1'b0;
            default: ec = logic'(h);
        endcase
        chk(dtag, "dout", dout, ed);
        chk(ctag, "cko", cko, ec);
        chk("R6", "dout_n", dout_n, ~ed);
        chk("R6", "cko_n", cko_n, (m == 2'b10) ? 1'b0 : ~ec);
        chk("R1", "mod_tick", mod_tick, logic'(h));
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    // Sends eight bits in mode m. vm marks the valid ticks (R9). With wiggle
    // set, mode_sel is flipped in the first half of period 3 (R7).
    task automatic run_bits(input logic [1:0] m, input logic [7:0] pat,
                            input logic [7:0] vm, input bit wiggle);
        string tg, dt;
        bit    changed;
        tg = mode_tag(m);
        dt = (vm != 8'hFF) ? "R9" : tg;
        while (!mod_tick) @(negedge clk);
        changed = (m != bmode);
        if (changed) per_idx = 0;
        bmode       = m;
        mode_sel    = m;
        mod_bit     = pat[0];
        mod_bit_vld = vm[0];
        if (vm[0]) bench_b = pat[0];
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check_half(m, 0, dt, tg);
            if (changed && k == 0) begin
                chk("R7", "cko after restart", cko, 1'b0);
                chk("R7", "mod_tick after restart", mod_tick, 1'b0);
            end
            if (wiggle && k == 3) mode_sel = m ^ 2'b10;
            @(negedge clk);
            check_half(m, 1, (wiggle && k == 3) ? "R7" : dt, (wiggle && k == 3) ? "R7" : tg);
            mode_sel = m;
            per_idx++;
            if (k < 7) begin
                mod_bit     = pat[k+1];
                mod_bit_vld = vm[k+1];
                if (vm[k+1]) bench_b = pat[k+1];
            end else begin
                mod_bit_vld = 1'b0;
            end
        end
    endtask

    task automatic check_reset_pins();
        chk("R8", "dout", dout, 1'b0);
        chk("R8", "dout_n", dout_n, 1'b0);
        chk("R8", "cko", cko, 1'b0);
        chk("R8", "cko_n", cko_n, 1'b0);
        chk("R8", "mod_tick", mod_tick, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_pins();
        rst = 1'b0;

        // Sweep every 8-bit pattern through each mode (R1 to R6)
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 256; p++) begin
                run_bits(2'(m), 8'(p), 8'hFF, 1'b0);
            end
        end

        // Mode 11 -> 01: divider restart (R7)
        run_bits(2'b01, 8'hA5, 8'hFF, 1'b0);
        // First-half mode glitches are ignored (R7)
        run_bits(2'b10, 8'h3C, 8'hFF, 1'b1);
        run_bits(2'b00, 8'h96, 8'hFF, 1'b1);
        run_bits(2'b10, 8'h69, 8'hFF, 1'b1);

        // Missing valids repeat the held bit (R9)
        for (int p = 0; p < 256; p++) begin
            run_bits(2'b11, 8'(p), 8'(p) ^ 8'h5A, 1'b0);
        end

        // Reset in mid-stream (R8)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_pins();
        repeat (2) @(negedge clk);
        check_reset_pins();
        rst     = 1'b0;
        bmode   = 2'b00;
        bench_b = 1'b0;
        run_bits(2'b01, 8'h5A, 8'hFF, 1'b0);
        run_bits(2'b10, 8'hC3, 8'hF0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule